// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer Channel

This block is one timer channel that sits on a simple register port. Software places an interval in the load register and sets the channel's mode in a control register. It then lets the counter step down once for each qualifying tick strobe. The tick comes from one of two strobe inputs that are generated elsewhere: a fast strobe near 508 kHz, or a slower alternate strobe. The control word picks which one.

When the count is already zero and one more tick arrives, the channel records an underflow and raises a level interrupt. In periodic mode the counter then restarts from the load register. In free-run mode it rolls over to all ones. The interrupt stays high until software writes anything to the clear register. The count width is a parameter, and both 16-bit and 32-bit channels are built from the same source.

To start a new interval, software first writes the control register with the run bit low, then writes the load value, then writes the control register again with the run bit high. Writing zero to the control register halts the channel.

Top module: `ivt_chan`

## Requirements
- R1: The count width CNT_W is a parameter, and both 16 and 32 are valid. The count and load value keep only the low CNT_W bits of written data. When either is read, the bits above CNT_W read as zero.
- R2: The register offsets on `addr` are 0x0 for load, 0x4 for the live count, 0x8 for control and 0xC for clear. Reads are combinational, and a read of the clear offset returns zero.
- R3: In the control word, bit 7 is run, bit 6 is periodic and bit 3 is fast-tick select. Only these bits are stored, and every other control bit reads as zero.
- R4: While run is set, the count drops by one on each cycle where the selected strobe is high. That is `tick_fast` when bit 3 is 1 and `tick_slow` when bit 3 is 0. The strobe that is not selected has no effect, and with run clear nothing counts.
- R5: A tick that arrives while the count is zero is an underflow. In periodic mode (bit 6 = 1) the counter then reloads from the load register, so a load of N yields one underflow every N+1 ticks.
- R6: In free-run mode (bit 6 = 0), an underflow sets the counter to all ones in CNT_W bits.
- R7: An underflow sets `irq` on the next cycle. `irq` stays high until a write to the clear offset, and the written data does not matter. After such a write, `irq` is low on the next cycle.
- R8: If a clear write and an underflow happen in the same cycle, `irq` stays high.
- R9: A write to the load offset copies the data into both the load register and the counter, visible on the next cycle. If a tick arrives in the same cycle, the write wins and no decrement or underflow occurs.
- R10: A control write does not change the count or the load value. Writing zero halts counting.
- R11: After reset, the count, the load value, the control word and `irq` are all zero.
- R12: Reading any register has no side effect on the count or on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| tick_fast | input | 1 | Fast tick strobe (about 508 kHz) |
| tick_slow | input | 1 | Alternate slower tick strobe |
| irq | output | 1 | Level interrupt, held until cleared |

## Verification
Two pairs of events can fall in the same cycle, and each is forced on purpose. The first pair is a write to the clear register and an underflow tick. The bench issues the clear write in the very cycle that a tick strikes a zero count. It expects `irq` to stay high while the counter reloads or wraps. The second pair is a load write and a tick. Here the bench expects the written value to win over the decrement. A behavioural reference model is compared with both a 32-bit and a 16-bit instance on every clock, under random writes and random strobes, so that other chance collisions are judged the same way.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int IVT_AW = 4;

    localparam logic [IVT_AW-1:0] OFF_LOAD = 4'h0;
    localparam logic [IVT_AW-1:0] OFF_CNT  = 4'h4;
    localparam logic [IVT_AW-1:0] OFF_CTRL = 4'h8;
    localparam logic [IVT_AW-1:0] OFF_CLR  = 4'hC;

    localparam int BIT_RUN  = 7;
    localparam int BIT_PER  = 6;
    localparam int BIT_FAST = 3;

    typedef struct packed {
        logic run;
        logic periodic;
        logic fast;
    } ivt_ctrl_t;

    typedef enum logic [1:0] {
        SEL_LOAD = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } ivt_rsel_e;
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
    import ivt_pkg::*;
(
    input  logic              wr_en,
    input  logic [IVT_AW-1:0] addr,
    output logic              wr_load,
    output logic              wr_ctrl,
    output logic              wr_clr,
    output ivt_rsel_e         rsel
);
    always_comb begin
        wr_load = wr_en && (addr == OFF_LOAD);
        wr_ctrl = wr_en && (addr == OFF_CTRL);
        wr_clr  = wr_en && (addr == OFF_CLR);
        unique case (addr)
            OFF_LOAD: rsel = SEL_LOAD;
            OFF_CNT:  rsel = SEL_CNT;
            OFF_CTRL: rsel = SEL_CTRL;
            default:  rsel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] load_data,
    input  ivt_ctrl_t        ctrl_data,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] load_val,
    output ivt_ctrl_t        ctrl,
    output logic             tick,
    output logic             underflow
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] load;
        ivt_ctrl_t        ctl;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       tick_d;
    logic       uf_d;

    always_comb begin
        s_d    = s_q;
        uf_d   = 1'b0;
        tick_d = s_q.ctl.run && (s_q.ctl.fast ? tick_fast : tick_slow);
        if (wr_load) begin
            s_d.cnt  = load_data;
            s_d.load = load_data;
        end else if (tick_d) begin
            if (s_q.cnt == '0) begin
                uf_d  = 1'b1;
                s_d.cnt = s_q.ctl.periodic ? s_q.load : {CNT_W{1'b1}};
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (wr_ctrl) begin
            s_d.ctl = ctrl_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt       = s_q.cnt;
    assign load_val  = s_q.load;
    assign ctrl      = s_q.ctl;
    assign tick      = tick_d;
    assign underflow = uf_d;
endmodule

// File: rtl/ivt_irq_flag.sv
module ivt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (set) begin
            irq_d = 1'b1;
        end else if (clr) begin
            irq_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/ivt_chan.sv
module ivt_chan
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IVT_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);
    logic             wr_load, wr_ctrl, wr_clr;
    ivt_rsel_e        rsel;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] load_val;
    ivt_ctrl_t        ctl;
    ivt_ctrl_t        ctl_wr;
    logic             tick_now;
    logic             uf;

    assign ctl_wr = '{run: wdata[BIT_RUN], periodic: wdata[BIT_PER], fast: wdata[BIT_FAST]};

    ivt_decode u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_load (wr_load),
        .wr_ctrl (wr_ctrl),
        .wr_clr  (wr_clr),
        .rsel    (rsel)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_load   (wr_load),
        .wr_ctrl   (wr_ctrl),
        .load_data (wdata[CNT_W-1:0]),
        .ctrl_data (ctl_wr),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .cnt       (cnt_val),
        .load_val  (load_val),
        .ctrl      (ctl),
        .tick      (tick_now),
        .underflow (uf)
    );

    ivt_irq_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (uf),
        .clr   (wr_clr),
        .irq   (irq)
    );

    always_comb begin
        rdata = '0;
        unique case (rsel)
            SEL_LOAD: rdata[CNT_W-1:0] = load_val;
            SEL_CNT:  rdata[CNT_W-1:0] = cnt_val;
            SEL_CTRL: begin
                rdata[BIT_RUN]  = ctl.run;
                rdata[BIT_PER]  = ctl.periodic;
                rdata[BIT_FAST] = ctl.fast;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivt_chan_chk.sv
module ivt_chan_chk
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IVT_AW-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  load_val,
    input logic              run,
    input logic              periodic,
    input logic              uf
);
    logic clr_wr, load_wr;
    assign clr_wr  = wr_en && (addr == OFF_CLR);
    assign load_wr = wr_en && (addr == OFF_LOAD);

    a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> irq);
    a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);
    a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !uf) |=> !irq);
    a_r8_clear_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && uf) |=> irq);
    a_r9_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cnt == $past(wdata)));
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && periodic) |=> (cnt == load_val));
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !periodic) |=> (cnt == {CNT_W{1'b1}}));
    a_r10_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_wr) |=> $stable(cnt));
endmodule

bind ivt_chan ivt_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata[CNT_W-1:0]),
    .irq      (irq),
    .cnt      (cnt_val),
    .load_val (load_val),
    .run      (ctl.run),
    .periodic (ctl.periodic),
    .uf       (uf)
);

// File: tb/tb_ivt_chan.sv
`timescale 1ns/1ps
module tb_ivt_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h4;
    logic [31:0] wdata = '0;
    logic        tf = 1'b0;
    logic        ts = 1'b0;
    logic [31:0] rd32, rd16;
    logic        irq32, irq16;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ivt_chan #(.CNT_W(32), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rd32), .tick_fast(tf), .tick_slow(ts), .irq(irq32));

    ivt_chan #(.CNT_W(16), .DATA_W(32)) dut16 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rd16), .tick_fast(tf), .tick_slow(ts), .irq(irq16));

    // behavioural reference: index 0 is the 32-bit channel, 1 the 16-bit one
    logic [31:0] m_cnt [2];
    logic [31:0] m_load[2];
    logic        m_irq [2];
    logic [31:0] m_ctrl;
    logic [31:0] m_mask[2];
    initial begin
        m_mask[0] = 32'hFFFF_FFFF;
        m_mask[1] = 32'h0000_FFFF;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_load[i] = 0; m_irq[i] = 0;
            end
            m_ctrl = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                bit t, under;
                t = m_ctrl[7] && (m_ctrl[3] ? tf : ts);
                under = 0;
                if (wr_en && addr == 4'h0) begin
                    m_cnt[i]  = wdata & m_mask[i];
                    m_load[i] = wdata & m_mask[i];
                end else if (t) begin
                    if (m_cnt[i] == 0) begin
                        under = 1;
                        m_cnt[i] = m_ctrl[6] ? m_load[i] : m_mask[i];
                    end else begin
                        m_cnt[i] = m_cnt[i] - 1;
                    end
                end
                if (under) m_irq[i] = 1;
                else if (wr_en && addr == 4'hC) m_irq[i] = 0;
            end
            if (wr_en && addr == 4'h8) m_ctrl = wdata & 32'h0000_00C8;
        end
    end

    function automatic logic [31:0] m_read(int i, logic [3:0] a);
        case (a)
            4'h0: return m_load[i];
            4'h4: return m_cnt[i];
            4'h8: return m_ctrl;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, between edges
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            check("R2 rdata32", rd32, m_read(0, addr));
            check("R1 rdata16", rd16, m_read(1, addr));
            check("R7 irq32", {31'b0, irq32}, {31'b0, m_irq[0]});
            check("R8 irq16", {31'b0, irq16}, {31'b0, m_irq[1]});
        end
    end

    task automatic drive(logic we, logic [3:0] a, logic [31:0] d, logic f, logic s);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; tf = f; ts = s;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        drive(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] e32, logic [31:0] e16);
        drive(1'b0, a, 32'h0, 1'b0, 1'b0);
        @(posedge clk); #5;
        check(tag, rd32, e32);
        check(tag, rd16, e16);
    endtask

    task automatic irq_chk(string tag, logic e);
        @(posedge clk); #6;
        check(tag, {31'b0, irq32}, {31'b0, e});
        check(tag, {31'b0, irq16}, {31'b0, e});
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rd_chk("R11 count", 4'h4, 0, 0);
        rd_chk("R11 load", 4'h0, 0, 0);
        rd_chk("R11 ctrl", 4'h8, 0, 0);
        irq_chk("R11 irq", 1'b0);
        // R3 only three control bits
        wr(4'h8, 32'hFFFF_FFFF);
        rd_chk("R3 ctrl bits", 4'h8, 32'hC8, 32'hC8);
        wr(4'h8, 32'h0);
        // R9 and R1 load copy / truncation
        wr(4'h0, 32'hABCD_1234);
        rd_chk("R9 load copy", 4'h4, 32'hABCD_1234, 32'h1234);
        rd_chk("R1 load trunc", 4'h0, 32'hABCD_1234, 32'h1234);
        // R5 periodic reload, R4 selection, R7 interrupt
        wr(4'h8, 32'h48);
        wr(4'h0, 32'd2);
        wr(4'h8, 32'hC8);
        drive(0, 4'h4, 0, 1, 0);
        drive(0, 4'h4, 0, 1, 0);
        rd_chk("R4 fast ticks", 4'h4, 0, 0);
        drive(0, 4'h4, 0, 0, 1);
        rd_chk("R4 slow ignored", 4'h4, 0, 0);
        irq_chk("R7 no irq yet", 1'b0);
        drive(0, 4'h4, 0, 1, 0);
        rd_chk("R5 reload", 4'h4, 2, 2);
        irq_chk("R7 irq set", 1'b1);
        rd_chk("R12 read no effect", 4'h4, 2, 2);
        irq_chk("R12 irq kept", 1'b1);
        wr(4'hC, 32'h0);
        rd_chk("R7 clear any data", 4'h4, 2, 2);
        irq_chk("R7 cleared", 1'b0);
        // R6 free-run wrap
        wr(4'h8, 32'h0);
        wr(4'h0, 32'd1);
        wr(4'h8, 32'h88);
        drive(0, 4'h4, 0, 1, 0);
        drive(0, 4'h4, 0, 1, 0);
        rd_chk("R6 wrap", 4'h4, 32'hFFFF_FFFF, 32'h0000_FFFF);
        irq_chk("R7 wrap irq", 1'b1);
        // R8 clear and underflow collide
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h5A);
        wr(4'h0, 32'd0);
        wr(4'h8, 32'h88);
        irq_chk("R7 clear before", 1'b0);
        drive(1, 4'hC, 32'h1, 1, 0);
        irq_chk("R8 set wins", 1'b1);
        // R9 load beats tick
        drive(1, 4'h0, 32'd7, 1, 0);
        rd_chk("R9 load priority", 4'h4, 7, 7);
        // R4 slow select
        wr(4'h8, 32'h80);
        wr(4'h0, 32'd4);
        drive(0, 4'h4, 0, 0, 1);
        rd_chk("R4 slow tick", 4'h4, 3, 3);
        drive(0, 4'h4, 0, 1, 0);
        rd_chk("R4 fast ignored", 4'h4, 3, 3);
        // R10 control write keeps count and load, zero halts
        wr(4'h8, 32'h0);
        rd_chk("R10 count kept", 4'h4, 3, 3);
        rd_chk("R10 load kept", 4'h0, 4, 4);
        drive(0, 4'h4, 0, 1, 1);
        rd_chk("R10 halted", 4'h4, 3, 3);
        rd_chk("R2 clear reads 0", 4'hC, 0, 0);
        // random phase, compared cycle by cycle
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            d = lfsr[20] ? (lfsr & 32'hF) : lfsr;
            if (lfsr[8:6] == 3'b000)
                drive(1, {lfsr[3:2], 2'b00}, d, lfsr[9], lfsr[10]);
            else
                drive(0, {lfsr[12:11], 2'b00}, 0, lfsr[9] | lfsr[13], lfsr[10] & lfsr[14]);
        end
        drive(0, 4'h4, 0, 0, 0);
        @(posedge clk); #8;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule